// File: doc/BRIEF.md
# Scratchpad-Buffered Protected Memory Controller

This block is the command engine behind a byte-serial nonvolatile memory. A transport layer below it turns wire activity into three kinds of event: a transaction restart (`bus_reset`), a byte received from the host (`rx_valid`/`rx_byte`), and a request for the next byte to send to the host (`tx_req`). The engine decodes the first byte after each restart as a command. It then runs one of four flows against a 32-byte staging buffer and a 2624-byte register array. The array holds 80 pages of 32 bytes, grouped into 10 blocks of 8 pages, followed by a 64-byte control area.

The host writes into the staging buffer, reads the buffer back together with the stored target address and a status byte, and then asks for a copy by echoing that address and status byte. The copy runs only when the echo matches exactly, no partial byte was written, no memory read came in between, and the target block is not copy-protected. Per-block protection codes in the control area change what the staging buffer captures. A write-protected block yields the byte already stored. A block in one-way mode yields the AND of the new byte and the stored byte. Programming is modelled as a fixed busy window of `PROG_CYCLES` clocks.

Top module: `spmem_ctrl`

## Requirements
- R1: After reset the array reads FFh everywhere and the stored target address is 0000h. The status byte reads 20h (partial flag set, ending offset 0), so a copy is refused until a valid buffer write occurs.
- R2: A two-byte target address (low byte first) above 0A3Fh has bits [15:12] cleared on capture. The buffer offset is the captured address bits [4:0].
- R3: Command 0Fh takes a target address, then stores data bytes at consecutive buffer offsets. The ending offset becomes the offset of the last stored byte, and bytes after offset 31 are ignored. The command clears the copy-done flag and the read-between flag. Each complete data byte clears the partial flag.
- R4: The protection byte for block n is at address 0A00h+n, where n is address bits [15:8] of a data address below 0A00h. When it holds 55h, the buffer captures the byte already in the array at the target instead of the host byte.
- R5: When the protection byte holds AAh, the buffer captures the bitwise AND of the host byte and the stored byte.
- R6: Command AAh returns, in order, the address low byte, the address high byte and the status byte. It then returns the buffer from offset T[4:0] up to offset 31, and FFh after that.
- R7: The status byte is {copy-done, 0, partial, ending offset[4:0]}. A restart that reports an unfinished byte during the data phase of 0Fh, before the buffer is full, sets the partial flag.
- R8: Command 55h takes three echo bytes (address low, address high, status). Any mismatch refuses the copy, and the engine then returns FFh until the next restart.
- R9: A copy is also refused when the partial flag is set, or when the read-between flag is set by a read command (F0h or A5h) after 0Fh. It is refused as well when the target block holds 55h while the lock byte at 0A0Ah holds 55h or AAh.
- R10: An accepted copy holds `busy` high for exactly `PROG_CYCLES` clocks and writes buffer offsets T[4:0] through the ending offset into the target page. It then sets the copy-done flag and returns AAh bytes (bit pattern 0,1,0,1 from LSB) until the next restart.
- R11: Commands F0h and A5h take a target address, then return consecutive array bytes, and FFh for every address past 0A3Fh.
- R12: `tx_valid` rises exactly one clock after each `tx_req`. Any unknown command byte makes the engine return FFh until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | Transaction restart from the transport layer |
| partial_byte | input | 1 | With bus_reset: an incomplete byte was pending |
| rx_valid | input | 1 | A host byte is present on rx_byte |
| rx_byte | input | 8 | Host byte |
| tx_req | input | 1 | Transport asks for the next byte to send |
| tx_valid | output | 1 | tx_byte holds the requested byte |
| tx_byte | output | 8 | Byte to send to the host |
| busy | output | 1 | Programming window in progress |

## Verification
The hardest state to reach from the ports is a copy refused purely by copy protection. It needs a fully matching echo, a clear partial flag, a clear read-between flag, a block coded 55h and a lock byte coded 55h. The lock and protection bytes can only be placed in the control area through the engine's own write-then-copy flow. The stimulus therefore first programs data into a block while it is open. It then writes the protection code and then the lock code through accepted copies. After that it performs a clean buffer write and a correct echo, so that the lock is the only reason left for refusal. The same staged setup also reaches the one-way AND capture and the stored-byte capture.

// File: rtl/spmem_pkg.sv
package spmem_pkg;
  localparam int PAGE_BYTES    = 32;
  localparam int PAGES         = 80;
  localparam int PAGES_PER_BLK = 8;
  localparam int CTRL_BYTES    = 64;

  localparam int DATA_BYTES = PAGE_BYTES * PAGES;
  localparam int MEM_BYTES  = DATA_BYTES + CTRL_BYTES;
  localparam int BLK_BYTES  = PAGE_BYTES * PAGES_PER_BLK;
  localparam int BLOCKS     = PAGES / PAGES_PER_BLK;
  localparam int CTRL_BASE  = DATA_BYTES;
  localparam int LOCK_ADDR  = CTRL_BASE + BLOCKS;
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int AW         = $clog2(MEM_BYTES);
  localparam int BLK_SH     = $clog2(BLK_BYTES);

  typedef logic [15:0] addr_t;

  localparam logic [7:0] CMD_WS   = 8'h0F;
  localparam logic [7:0] CMD_RS   = 8'hAA;
  localparam logic [7:0] CMD_CP   = 8'h55;
  localparam logic [7:0] CMD_RM   = 8'hF0;
  localparam logic [7:0] CMD_XRM  = 8'hA5;
  localparam logic [7:0] CODE_WP  = 8'h55;
  localparam logic [7:0] CODE_EP  = 8'hAA;
  localparam logic [7:0] DONE_PAT = 8'hAA;

  typedef enum logic [3:0] {
    ST_CMD, ST_WS_A, ST_WS_D, ST_RS, ST_CP_A,
    ST_RM_A, ST_RM_D, ST_BUSY, ST_DONE, ST_IGN
  } st_t;

  function automatic logic addr_ok(addr_t a);
    return a < addr_t'(MEM_BYTES);
  endfunction

  function automatic addr_t mask_addr(addr_t a);
    if (!addr_ok(a)) return {4'h0, a[11:0]};
    return a;
  endfunction

  function automatic logic [7:0] merge_byte(logic [7:0] host, logic [7:0] cur,
                                            logic wp, logic ep);
    if (wp) return cur;
    if (ep) return host & cur;
    return host;
  endfunction

  function automatic logic [7:0] status_byte(logic aa, logic pf, logic [OFF_W-1:0] e);
    return {aa, 1'b0, pf, e};
  endfunction
endpackage

// File: rtl/spmem_scratch.sv
module spmem_scratch
  import spmem_pkg::*;
#(
  parameter int DEPTH = PAGE_BYTES,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata
);
  logic [7:0] buf_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= 8'hFF;
    end else if (we) begin
      buf_q[widx] <= wdata;
    end
  end

  assign rdata = buf_q[ridx];
endmodule

// File: rtl/spmem_array.sv
module spmem_array
  import spmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  addr_t      rd_addr,
  output logic [7:0] rd_data,
  output logic       rd_wp,
  output logic       rd_ep,
  output logic       rd_cp,
  input  logic       wr_en,
  input  addr_t      wr_addr,
  input  logic [7:0] wr_data
);
  logic [7:0] mem [MEM_BYTES];
  logic [BLOCKS-1:0] wp_vec, ep_vec;
  logic in_data, locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (wr_en && addr_ok(wr_addr)) begin
      mem[wr_addr[AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = addr_ok(rd_addr) ? mem[rd_addr[AW-1:0]] : 8'hFF;
  assign in_data = rd_addr < addr_t'(DATA_BYTES);
  assign locked  = (mem[LOCK_ADDR] == CODE_WP) || (mem[LOCK_ADDR] == CODE_EP);

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    logic hit;
    assign hit       = in_data && (rd_addr[15:BLK_SH] == (16-BLK_SH)'(b));
    assign wp_vec[b] = hit && (mem[CTRL_BASE+b] == CODE_WP);
    assign ep_vec[b] = hit && (mem[CTRL_BASE+b] == CODE_EP);
  end

  assign rd_wp = |wp_vec;
  assign rd_ep = |ep_vec;
  assign rd_cp = rd_wp && locked;
endmodule

// File: rtl/spmem_ctrl.sv
module spmem_ctrl
  import spmem_pkg::*;
#(
  parameter int PROG_CYCLES = 40,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       partial_byte,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       busy
);
  st_t              st;
  logic [1:0]       idx;
  logic [7:0]       ta_lo;
  addr_t            ta_q, rm_addr, ta_in, rd_addr;
  logic [OFF_W-1:0] e_q, off_q, cp_ptr, sp_ridx;
  logic             pf_q, aa_q, bs_q, sp_full, mism, cp_done;
  logic [5:0]       rs_cnt;
  logic [6:0]       rs_pos;
  logic             rs_in;
  logic [CW-1:0]    cnt;
  logic [7:0]       rd_data, sp_rdata, merged, exp_echo, tx_next, stat;
  logic             arr_wp, arr_ep, arr_cp;

  // named internal events, observed by the checker
  logic ev_ws_cmd, ev_rm_cmd, ev_ws_store, echo_last, ev_copy_go, ev_prog_end;

  assign stat        = status_byte(aa_q, pf_q, e_q);
  assign ta_in       = mask_addr({rx_byte, ta_lo});
  assign ev_ws_cmd   = rx_valid && !bus_reset && st == ST_CMD && rx_byte == CMD_WS;
  assign ev_rm_cmd   = rx_valid && !bus_reset && st == ST_CMD &&
                       (rx_byte == CMD_RM || rx_byte == CMD_XRM);
  assign ev_ws_store = rx_valid && !bus_reset && st == ST_WS_D && !sp_full;
  assign echo_last   = rx_valid && !bus_reset && st == ST_CP_A && idx == 2'd2;
  assign ev_copy_go  = echo_last && !mism && rx_byte == exp_echo &&
                       !pf_q && !bs_q && !arr_cp;
  assign ev_prog_end = st == ST_BUSY && cnt == '0;

  always_comb begin
    case (idx)
      2'd0:    exp_echo = ta_q[7:0];
      2'd1:    exp_echo = ta_q[15:8];
      default: exp_echo = stat;
    endcase
  end

  always_comb begin
    case (st)
      ST_WS_D: rd_addr = {ta_q[15:OFF_W], off_q};
      ST_RM_D: rd_addr = rm_addr;
      default: rd_addr = ta_q;
    endcase
  end

  assign rs_pos  = 7'(ta_q[OFF_W-1:0]) + 7'(rs_cnt) - 7'd3;
  assign rs_in   = rs_cnt >= 6'd3 && rs_pos < 7'(PAGE_BYTES);
  assign sp_ridx = (st == ST_BUSY) ? cp_ptr : rs_pos[OFF_W-1:0];
  assign merged  = merge_byte(rx_byte, rd_data, arr_wp, arr_ep);

  spmem_scratch #(.DEPTH(PAGE_BYTES)) u_sp (
    .clk(clk), .rst_n(rst_n), .we(ev_ws_store), .widx(off_q), .wdata(merged),
    .ridx(sp_ridx), .rdata(sp_rdata)
  );

  spmem_array u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_wp(arr_wp), .rd_ep(arr_ep), .rd_cp(arr_cp),
    .wr_en(st == ST_BUSY && !cp_done), .wr_addr({ta_q[15:OFF_W], cp_ptr}),
    .wr_data(sp_rdata)
  );

  always_comb begin
    case (st)
      ST_RS: begin
        if (rs_cnt == 6'd0)      tx_next = ta_q[7:0];
        else if (rs_cnt == 6'd1) tx_next = ta_q[15:8];
        else if (rs_cnt == 6'd2) tx_next = stat;
        else                     tx_next = rs_in ? sp_rdata : 8'hFF;
      end
      ST_RM_D: tx_next = rd_data;
      ST_DONE: tx_next = DONE_PAT;
      default: tx_next = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= 8'hFF;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) tx_byte <= tx_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_CMD;  idx <= '0;  ta_lo <= '0;  ta_q <= '0;  rm_addr <= '0;
      e_q <= '0;  off_q <= '0;  cp_ptr <= '0;  pf_q <= 1'b1;  aa_q <= 1'b0;
      bs_q <= 1'b0;  sp_full <= 1'b0;  mism <= 1'b0;  cp_done <= 1'b0;
      rs_cnt <= '0;  cnt <= '0;  busy <= 1'b0;
    end else if (st == ST_BUSY) begin
      if (!cp_done) begin
        if (cp_ptr == e_q) cp_done <= 1'b1;
        else cp_ptr <= cp_ptr + 1'b1;
      end
      if (ev_prog_end) begin
        busy <= 1'b0;
        aa_q <= 1'b1;
        st   <= ST_DONE;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (bus_reset) begin
      if (st == ST_WS_D && partial_byte && !sp_full) pf_q <= 1'b1;
      st <= ST_CMD;
    end else begin
      if (rx_valid) begin
        case (st)
          ST_CMD: begin
            idx <= '0;
            if (rx_byte == CMD_WS) begin
              st <= ST_WS_A;  pf_q <= 1'b1;  aa_q <= 1'b0;  bs_q <= 1'b0;
            end else if (rx_byte == CMD_RS) begin
              st <= ST_RS;  rs_cnt <= '0;
            end else if (rx_byte == CMD_CP) begin
              st <= ST_CP_A;  mism <= 1'b0;
            end else if (ev_rm_cmd) begin
              st <= ST_RM_A;  bs_q <= 1'b1;
            end else begin
              st <= ST_IGN;
            end
          end
          ST_WS_A: begin
            if (idx == 2'd0) begin
              ta_lo <= rx_byte;  idx <= 2'd1;
            end else begin
              ta_q    <= ta_in;
              off_q   <= ta_in[OFF_W-1:0];
              sp_full <= 1'b0;
              st      <= ST_WS_D;
            end
          end
          ST_WS_D: begin
            if (!sp_full) begin
              e_q  <= off_q;
              pf_q <= 1'b0;
              if (off_q == OFF_W'(PAGE_BYTES - 1)) sp_full <= 1'b1;
              else off_q <= off_q + 1'b1;
            end
          end
          ST_CP_A: begin
            if (rx_byte != exp_echo) mism <= 1'b1;
            idx <= idx + 1'b1;
            if (idx == 2'd2) begin
              if (ev_copy_go) begin
                st      <= ST_BUSY;
                busy    <= 1'b1;
                cnt     <= CW'(PROG_CYCLES - 1);
                cp_ptr  <= ta_q[OFF_W-1:0];
                cp_done <= 1'b0;
              end else begin
                st <= ST_IGN;
              end
            end
          end
          ST_RM_A: begin
            if (idx == 2'd0) begin
              ta_lo <= rx_byte;  idx <= 2'd1;
            end else begin
              rm_addr <= ta_in;
              st      <= ST_RM_D;
            end
          end
          default: ;
        endcase
      end
      if (tx_req) begin
        if (st == ST_RS && rs_cnt != 6'h3F) rs_cnt <= rs_cnt + 1'b1;
        if (st == ST_RM_D && rm_addr != 16'hFFFF) rm_addr <= rm_addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spmem_ctrl_chk.sv
module spmem_ctrl_chk
  import spmem_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  busy,
  input logic  tx_req,
  input logic  tx_valid,
  input logic  rx_valid,
  input logic  aa_q,
  input logic  pf_q,
  input logic  bs_q,
  input addr_t ta_q,
  input logic  ev_ws_cmd,
  input logic  ev_ws_store,
  input logic  ev_copy_go,
  input logic  ev_rm_cmd
);
  p_mask_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ta_q[15:12] == 4'h0);

  p_ws_clears_aa_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ws_cmd |=> (!aa_q && pf_q && !bs_q));

  p_store_clears_pf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ws_store |=> !pf_q);

  p_read_sets_bs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rm_cmd |=> bs_q);

  p_copy_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_copy_go |=> busy);

  p_busy_from_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rx_valid));

  p_end_sets_aa_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> aa_q);

  p_no_store_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_ws_store);

  p_tx_handshake_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req));
endmodule

bind spmem_ctrl spmem_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_req(tx_req), .tx_valid(tx_valid),
  .rx_valid(rx_valid), .aa_q(aa_q), .pf_q(pf_q), .bs_q(bs_q), .ta_q(ta_q),
  .ev_ws_cmd(ev_ws_cmd), .ev_ws_store(ev_ws_store), .ev_copy_go(ev_copy_go),
  .ev_rm_cmd(ev_rm_cmd)
);

// File: tb/tb_spmem_ctrl.sv
module tb_spmem_ctrl;
  localparam int CLK_NS = 10;
  localparam int PROG   = 40;

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, partial_byte = 1'b0;
  logic rx_valid = 1'b0, tx_req = 1'b0, tx_valid, busy;
  logic [7:0] rx_byte = 8'h00, tx_byte;

  spmem_ctrl #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .partial_byte(partial_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .busy(busy)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0]  m_mem [0:2623];
  logic [7:0]  m_sp  [0:31];
  logic [15:0] m_ta = 16'h0000;
  int          m_e = 0;
  bit          m_pf = 1, m_aa = 0, m_bs = 0;
  logic        req_d = 1'b0;

  initial begin
    for (int i = 0; i < 2624; i++) m_mem[i] = 8'hFF;
    for (int i = 0; i < 32; i++)   m_sp[i]  = 8'hFF;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) req_d <= tx_req;
  always @(negedge clk) if (rst_n && !done) chk("R12 tx_valid timing", int'(tx_valid), int'(req_d));

  function automatic logic [15:0] m_mask(logic [15:0] a);
    return (a > 16'h0A3F) ? (a & 16'h0FFF) : a;
  endfunction
  function automatic logic [7:0] m_rd(int a);
    return (a < 2624) ? m_mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] m_code(int a);
    return (a < 2560) ? m_mem[2560 + a / 256] : 8'h00;
  endfunction
  function automatic bit m_lock();
    return m_mem[2570] == 8'h55 || m_mem[2570] == 8'hAA;
  endfunction
  function automatic logic [7:0] m_status();
    return {m_aa, 1'b0, m_pf, 5'(m_e)};
  endfunction

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic get(output logic [7:0] b);
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    b = tx_byte;
  endtask

  task automatic brst(input bit p);
    bus_reset = 1'b1; partial_byte = p;
    @(negedge clk);
    bus_reset = 1'b0; partial_byte = 1'b0;
  endtask

  task automatic ws(input logic [15:0] a, input int n, input logic [7:0] d0, d1, d2, d3,
                    input bit partial);
    logic [7:0] d [4];
    int off, ad;
    bit full;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    brst(0);
    send(8'h0F); send(a[7:0]); send(a[15:8]);
    m_ta = m_mask(a); m_pf = 1; m_aa = 0; m_bs = 0;
    off = int'(m_ta[4:0]); full = 0;
    for (int k = 0; k < n; k++) begin
      send(d[k]);
      if (!full) begin
        ad = int'({m_ta[15:5], 5'(off)});
        if (m_code(ad) == 8'h55)      m_sp[off] = m_rd(ad);
        else if (m_code(ad) == 8'hAA) m_sp[off] = d[k] & m_rd(ad);
        else                          m_sp[off] = d[k];
        m_e = off; m_pf = 0;
        if (off == 31) full = 1; else off++;
      end
    end
    if (partial && !full) m_pf = 1;
    brst(partial);
  endtask

  task automatic rs(input string req, input int n);
    logic [7:0] b, e;
    int pos;
    brst(0);
    send(8'hAA);
    for (int k = 0; k < n; k++) begin
      get(b);
      if (k == 0)      e = m_ta[7:0];
      else if (k == 1) e = m_ta[15:8];
      else if (k == 2) e = m_status();
      else begin
        pos = int'(m_ta[4:0]) + k - 3;
        e = (pos < 32) ? m_sp[pos] : 8'hFF;
      end
      chk(req, int'(b), int'(e));
    end
  endtask

  task automatic cp(input string req, input logic [7:0] lo, hi, es);
    bit ok;
    int n;
    logic [7:0] b;
    brst(0);
    send(8'h55); send(lo); send(hi);
    ok = lo == m_ta[7:0] && hi == m_ta[15:8] && es == m_status() && !m_pf && !m_bs &&
         !(m_code(int'(m_ta)) == 8'h55 && m_lock());
    send(es);
    if (ok) begin
      n = 0;
      while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
      chk({req, " busy length"}, n, PROG);
      for (int o = int'(m_ta[4:0]); o <= m_e; o++)
        if (int'({m_ta[15:5], 5'(o)}) < 2624) m_mem[int'({m_ta[15:5], 5'(o)})] = m_sp[o];
      m_aa = 1;
      for (int k = 0; k < 2; k++) begin get(b); chk({req, " done pattern"}, int'(b), 8'hAA); end
    end else begin
      chk({req, " refused busy"}, int'(busy), 0);
      get(b); chk({req, " refused ones"}, int'(b), 8'hFF);
    end
  endtask

  task automatic rm(input string req, input logic [15:0] a, input int n, input logic [7:0] cmd);
    logic [7:0] b;
    int p;
    brst(0);
    send(cmd); send(a[7:0]); send(a[15:8]);
    m_bs = 1; p = int'(m_mask(a));
    for (int k = 0; k < n; k++) begin
      get(b); chk(req, int'(b), int'(m_rd(p))); p++;
    end
  endtask

  task automatic set_reg(input logic [15:0] a, input logic [7:0] v);
    ws(a, 1, v, 0, 0, 0, 0);
    cp("R10 control write", a[7:0], a[15:8], {3'b000, a[4:0]});
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R12 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    rs("R1 reset status", 5);
    rm("R1 erased array", 16'h0000, 2, 8'hF0);
    ws(16'h0010, 3, 8'h11, 8'h22, 8'h33, 0, 0);
    rs("R6 scratchpad readback", 3 + 16 + 2);
    cp("R8 echo mismatch", 8'h10, 8'h00, 8'h00);
    rm("R8 memory untouched", 16'h0010, 3, 8'hF0);
    ws(16'h0010, 3, 8'h11, 8'h22, 8'h33, 0, 0);
    cp("R10 copy", 8'h10, 8'h00, 8'h12);
    rs("R7 status after copy", 3);
    rm("R10 copied data", 16'h000E, 6, 8'hF0);
    ws(16'h0020, 1, 8'h44, 0, 0, 0, 0);
    rm("R9 read between", 16'h0000, 1, 8'hF0);
    cp("R9 blocked by read", 8'h20, 8'h00, 8'h00);
    ws(16'h0020, 1, 8'h44, 0, 0, 0, 0);
    rm("R11 extended read", 16'h0020, 1, 8'hA5);
    cp("R9 blocked by extended read", 8'h20, 8'h00, 8'h00);
    ws(16'h0040, 2, 8'h55, 8'h66, 0, 0, 1);
    rs("R7 partial flag", 3);
    cp("R9 blocked by partial", 8'h40, 8'h00, 8'h21);
    ws(16'h0100, 1, 8'h3C, 0, 0, 0, 0);
    cp("R10 open block copy", 8'h00, 8'h01, 8'h00);
    set_reg(16'h0A01, 8'h55);
    ws(16'h0100, 1, 8'h12, 0, 0, 0, 0);
    rs("R4 write protect capture", 4);
    cp("R4 protected copy", 8'h00, 8'h01, 8'h00);
    rm("R4 protected data", 16'h0100, 1, 8'hF0);
    ws(16'h0200, 1, 8'hF0, 0, 0, 0, 0);
    cp("R10 block2 copy", 8'h00, 8'h02, 8'h00);
    set_reg(16'h0A02, 8'hAA);
    ws(16'h0200, 1, 8'h3C, 0, 0, 0, 0);
    rs("R5 and capture", 4);
    cp("R5 one-way copy", 8'h00, 8'h02, 8'h00);
    rm("R5 one-way result", 16'h0200, 1, 8'hF0);
    set_reg(16'h0A0A, 8'h55);
    ws(16'h0100, 1, 8'h12, 0, 0, 0, 0);
    cp("R9 copy protected", 8'h00, 8'h01, 8'h00);
    rm("R9 locked data", 16'h0100, 1, 8'hF0);
    ws(16'h0201, 1, 8'h0F, 0, 0, 0, 0);
    cp("R9 one-way block under lock", 8'h01, 8'h02, 8'h01);
    ws(16'h3A05, 1, 8'h77, 0, 0, 0, 0);
    rs("R2 masked address", 4);
    ws(16'hFFE3, 1, 8'h5A, 0, 0, 0, 0);
    rs("R2 masked invalid address", 4);
    rm("R2 masked read", 16'h1010, 2, 8'hF0);
    rm("R11 end of memory", 16'h0A3E, 4, 8'hF0);
    ws(16'h001E, 4, 8'h01, 8'h02, 8'h03, 8'h04, 0);
    rs("R3 scratchpad overflow", 3 + 2 + 2);
    brst(0);
    send(8'h99);
    get(b);
    chk("R12 unknown command", int'(b), 8'hFF);
    done = 1;
    summary();
    $finish;
  end
endmodule